// File: doc/BRIEF.md
# Threshold Crossing Trigger Detector

This block watches a stream of 16-bit sample codes and decides, on every clock cycle that carries a valid sample, whether that sample lies strictly above a programmable threshold. The decision is kept in a state register. Both the over-threshold level and a digital trigger line are driven from that register, so downstream logic always sees a clean, clocked level and never a raw comparator output.

When a valid sample's comparison differs from the stored state, the state register flips. In that same cycle the block raises a change pulse that lasts exactly one clock. A flip can go either way: the sample rises above the threshold, or it falls back to or below it. Cycles without a valid sample leave the state alone. Samples and the threshold are compared as two's-complement numbers by default. An unsigned compare can be chosen at elaboration.

Top module: `thresh_cross_trig`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it is released, over_lvl, dout_line and chg_pulse are all 0.
- R2: With the default signed mode, the compare treats smp_data and thr_level as two's-complement values (bit 15 is the sign). For example, -5 is above -10, and 0x8000 (-32768) is not above 0x7FFF.
- R3: The compare is strict. A sample equal to the threshold gives an over_lvl of 0.
- R4: The state updates only in a cycle where smp_vld is 1. When smp_vld is 0, over_lvl keeps its value whatever smp_data and thr_level do.
- R5: When a valid sample's compare result differs from the stored state, chg_pulse is 1 for exactly one cycle. That cycle is the one in which over_lvl shows the new value, for both a rising and a falling crossing.
- R6: A valid sample whose compare result equals the stored state produces no chg_pulse.
- R7: dout_line always equals over_lvl.
- R8: A valid sample presented before a clock edge is reflected on over_lvl right after that edge. With a threshold of 0 and a sample of 2000, the output is therefore high one cycle after the first valid sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_data | input | 16 | Sample code |
| smp_vld | input | 1 | Sample valid strobe |
| thr_level | input | 16 | Threshold code |
| over_lvl | output | 1 | Registered result of the compare: sample above threshold |
| dout_line | output | 1 | Digital trigger line, driven from the registered state |
| chg_pulse | output | 1 | One-cycle pulse when the stored state toggles |

## Verification
The only internal state is one bit, and it appears directly on over_lvl and dout_line. A wrong state is therefore visible at the ports in the cycle right after the edge that stored it. The cases to watch are the following. A compare that is unsigned or non-strict makes over_lvl wrong after a single sample at a sign boundary or at equality. A pulse that is lost or left high for a second cycle shows up against an expected toggle of over_lvl in that same cycle. A state that moves while smp_vld is low changes over_lvl one cycle after the invalid stimulus.

// File: rtl/thr_pkg.sv
package thr_pkg;

   typedef enum logic {
      CMP_SIGNED   = 1'b0,
      CMP_UNSIGNED = 1'b1
   } cmp_mode_e;

   localparam int unsigned DEF_SMP_W = 16;

endpackage

// File: rtl/thr_compare.sv
module thr_compare #(
   parameter int unsigned        W    = thr_pkg::DEF_SMP_W,
   parameter thr_pkg::cmp_mode_e MODE = thr_pkg::CMP_SIGNED
) (
   input  logic [W-1:0] a_val,
   input  logic [W-1:0] b_val,
   output logic         a_gt_b
);

   generate
      if (W < 2) begin : g_bad_width
         $error("thr_compare: W must be at least 2");
      end
      if (MODE == thr_pkg::CMP_SIGNED) begin : g_signed
         assign a_gt_b = $signed(a_val) > $signed(b_val);
      end else begin : g_unsigned
         assign a_gt_b = a_val > b_val;
      end
   endgenerate

endmodule

// File: rtl/thr_state_track.sv
module thr_state_track (
   input  logic clk,
   input  logic rst,
   input  logic upd_en,
   input  logic cmp_now,
   output logic state_q,
   output logic toggle_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= 1'b0;
         toggle_q <= 1'b0;
      end else begin
         toggle_q <= upd_en && (cmp_now != state_q);
         if (upd_en) begin
            state_q <= cmp_now;
         end
      end
   end

   // R5: a pulse coincides with a flip of the state
   assert_pulse_on_flip_R5: assert property (@(posedge clk) disable iff (rst)
      toggle_q |-> (state_q != $past(state_q)));

   // R6: a flip of the state never happens without a pulse
   assert_flip_has_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      (state_q != $past(state_q)) |-> toggle_q);

   // R4: no update without the enable
   assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
      !upd_en |=> ($stable(state_q) && !toggle_q));

   // R1: reset clears state and pulse
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!state_q && !toggle_q));

endmodule

// File: rtl/thresh_cross_trig.sv
module thresh_cross_trig #(
   parameter int unsigned        SMP_W    = thr_pkg::DEF_SMP_W,
   parameter thr_pkg::cmp_mode_e CMP_MODE = thr_pkg::CMP_SIGNED
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SMP_W-1:0] smp_data,
   input  logic             smp_vld,
   input  logic [SMP_W-1:0] thr_level,
   output logic             over_lvl,
   output logic             dout_line,
   output logic             chg_pulse
);

   logic cmp_gt;
   logic st_q;
   logic tg_q;

   thr_compare #(
      .W    (SMP_W),
      .MODE (CMP_MODE)
   ) u_cmp (
      .a_val  (smp_data),
      .b_val  (thr_level),
      .a_gt_b (cmp_gt)
   );

   thr_state_track u_state (
      .clk      (clk),
      .rst      (rst),
      .upd_en   (smp_vld),
      .cmp_now  (cmp_gt),
      .state_q  (st_q),
      .toggle_q (tg_q)
   );

   assign over_lvl  = st_q;
   assign dout_line = st_q;
   assign chg_pulse = tg_q;

   // R3: equality never reads as over threshold
   assert_equal_not_over_R3: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && (smp_data == thr_level)) |=> !over_lvl);

   // R8: a valid sample is reflected after one edge
   assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
      smp_vld |=> (over_lvl == $past(cmp_gt)));

   // R7: trigger line follows the level
   always_comb begin
      assert_dout_follows_R7: assert (dout_line == over_lvl);
   end

endmodule

// File: tb/tb_thresh_cross_trig.sv
`timescale 1ns/1ps
module tb_thresh_cross_trig;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] smp_data;
   logic        smp_vld;
   logic [15:0] thr_level;
   logic        over_lvl, dout_line, chg_pulse;

   int n_chk = 0;
   int n_err = 0;
   logic m_st = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   thresh_cross_trig dut (
      .clk(clk), .rst(rst), .smp_data(smp_data), .smp_vld(smp_vld),
      .thr_level(thr_level), .over_lvl(over_lvl), .dout_line(dout_line),
      .chg_pulse(chg_pulse)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step(input logic [15:0] d, input logic v, input logic [15:0] t,
                       input string tag);
      logic gt, pulse;
      @(negedge clk);
      smp_data = d; smp_vld = v; thr_level = t;
      gt    = $signed(d) > $signed(t);
      pulse = v && (gt != m_st);
      if (v) m_st = gt;
      @(posedge clk); #5;
      chk({tag, " over_lvl"}, over_lvl, m_st);
      chk({tag, " dout_line R7"}, dout_line, m_st);
      chk({tag, " chg_pulse"}, chg_pulse, pulse);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; smp_vld = 1'b0; smp_data = 16'd0; thr_level = 16'd0;
      repeat (2) @(posedge clk);
      #5;
      chk("R1 over_lvl in reset", over_lvl, 1'b0);
      chk("R1 chg_pulse in reset", chg_pulse, 1'b0);
      @(negedge clk);
      rst = 1'b0; m_st = 1'b0;
      @(posedge clk); #5;
      chk("R1 over_lvl after release", over_lvl, 1'b0);
      chk("R1 dout_line after release", dout_line, 1'b0);
      chk("R1 chg_pulse after release", chg_pulse, 1'b0);
   endtask

   task automatic t_startup();
      step(16'd2000, 1'b1, 16'd0, "R8 start 2000>0");
      step(16'd2000, 1'b1, 16'd0, "R6 steady high");
   endtask

   task automatic t_equal();
      step(16'd100, 1'b1, 16'd100, "R3 equal drops");
      step(16'd101, 1'b1, 16'd100, "R3 one above");
      step(16'd100, 1'b1, 16'd100, "R5 falling on equal");
   endtask

   task automatic t_signed();
      step(16'hFFFB, 1'b1, 16'hFFF6, "R2 -5 > -10");
      step(16'h8000, 1'b1, 16'h7FFF, "R2 min vs max");
      step(16'h7FFF, 1'b1, 16'h8000, "R2 max vs min");
      step(16'hFFFF, 1'b1, 16'h0000, "R2 -1 vs 0");
   endtask

   task automatic t_hold();
      step(16'd500, 1'b1, 16'd10, "R5 rise");
      step(16'd0,   1'b0, 16'd10, "R4 invalid low sample");
      step(16'h8000, 1'b0, 16'h7FFF, "R4 invalid extreme");
      step(16'd0,   1'b1, 16'd10, "R5 fall");
      step(16'd900, 1'b0, 16'd10, "R4 invalid high sample");
   endtask

   task automatic t_toggle();
      for (int i = 0; i < 6; i++) begin
         step((i % 2 == 0) ? 16'd50 : 16'd5, 1'b1, 16'd20, "R5 alternate");
      end
      step(16'd5, 1'b1, 16'd20, "R6 steady low");
   endtask

   task automatic t_mid_reset();
      step(16'd300, 1'b1, 16'd1, "R5 rise before reset");
      do_reset();
   endtask

   initial begin
      rst = 1'b1; smp_vld = 1'b0; smp_data = '0; thr_level = '0;
      do_reset();
      t_startup();
      t_equal();
      t_signed();
      t_hold();
      t_toggle();
      t_mid_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule